// File: doc/BRIEF.md
# Configuration RAM Front End with Password Lock

This block sits behind a PC-style index/data I/O port pair and fronts a byte-wide, 128-location configuration RAM held in internal registers. Software writes a 7-bit offset to the index port (0x70), then reads or writes the selected byte through the data port (0x71). The low fourteen offsets hold the time, alarm and status bytes. Offsets up to 0x3F are general storage, and 0x40 to 0x7F form a second storage bank.

Two protections are layered on top of plain access. The first is a one-way lock, armed through bit 3 of the system control port (0x92) while a configuration enable input is high. Once armed, the lock hides the eight-byte password window at offsets 0x38 to 0x3F until the next system reset. The second is a validity flag in bit 7 of status byte 0x0D. A rising edge on a power-detect input clears this flag. The input passes through a two-flop synchronizer before the edge is detected.

Top module: `cmos_lock_top`

## Requirements
- R1: After reset the lock is clear, port 0x92 reads 0x00, and the validity flag (bit 7 of offset 0x0D) reads 0.
- R2: A write to port 0x70 latches bits 6:0 as the offset and ignores bit 7. Port 0x71 then reads or writes the byte at that offset, across all 128 offsets including the 0x40 to 0x7F bank.
- R3: A write to port 0x92 with bit 3 = 1 while the config enable is high sets the lock. A read of port 0x92 returns the lock in bit 3, with all other bits 0.
- R4: While locked, a data-port read at offsets 0x38 to 0x3F returns 0xFF. Offsets 0x37 and 0x40 still read their stored bytes.
- R5: While locked, a data-port write at offsets 0x38 to 0x3F is discarded and leaves the stored byte unchanged.
- R6: Neither writing 0 to bit 3 of port 0x92 nor dropping the config enable clears a lock that is already set.
- R7: An arming write to port 0x92 while the config enable is low does not set the lock.
- R8: System reset clears the lock, after which the window is readable and writable again. Reset does not alter RAM contents.
- R9: Writing offset 0x0D sets the validity flag from data bit 7, and bits 6:0 are stored normally. A synchronized rising edge of the power-detect input clears the flag within three clock edges. The flag stays clear until software rewrites it, and a power-detect input held high does not clear it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low system reset |
| ioWrEn | input | 1 | I/O write strobe, one cycle per write |
| ioRdEn | input | 1 | I/O read enable; read data is combinational |
| ioAddr | input | 16 | I/O port address |
| ioWrData | input | 8 | I/O write data |
| ioRdData | output | 8 | I/O read data (0x00 for unclaimed ports) |
| protEnable | input | 1 | Config enable that permits arming the lock |
| pwrDetect | input | 1 | Asynchronous power-loss detect input |

## Verification
On every cycle, assertions check the following:
- A set lock never falls.
- A lock can only rise after the config enable was high.
- No RAM write strobe reaches a window offset while the lock is set.
- A blocked window read drives 0xFF.
- The validity flag is low the cycle after a detected power edge.

Only the bench scenarios can show the remaining behaviour. These include that discarded writes leave the old bytes in place, that RAM contents survive reset, that the index port drops bit 7, and the full sequence of validity set, edge clear and rewrite under a held-high detect input.

// File: rtl/cmos_lock_pkg.sv
package cmos_lock_pkg;

  typedef struct packed {
    logic idxWr;    // latch new offset
    logic ramWr;    // write byte at latched offset (already gated)
    logic rdRam;    // data port read selected
    logic rdCtl;    // control port read selected
    logic blocked;  // latched offset is inside a locked window
  } ctrlStrobes_t;

endpackage

// File: rtl/cmos_lock_ctrl.sv
module cmos_lock_ctrl
  import cmos_lock_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int IDX_W     = 7,
  parameter int IDX_PORT  = 'h70,
  parameter int DATA_PORT = 'h71,
  parameter int CTL_PORT  = 'h92,
  parameter int ARM_BIT   = 3,
  parameter int WIN_BASE  = 'h38,
  parameter int WIN_SIZE  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioWrEn,
  input  logic              ioRdEn,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [DATA_W-1:0] ioWrData,
  input  logic              protEnable,
  input  logic              pwrDetect,
  input  logic [IDX_W-1:0]  idxQ,
  output ctrlStrobes_t      stb,
  output logic              lockQ,
  output logic              vrtClr
);

  localparam int WIN_LAST = WIN_BASE + WIN_SIZE - 1;

  logic hitIdx, hitData, hitCtl, inWindow, armWr;
  logic [2:0] syncQ;

  assign hitIdx   = (ioAddr == ADDR_W'(IDX_PORT));
  assign hitData  = (ioAddr == ADDR_W'(DATA_PORT));
  assign hitCtl   = (ioAddr == ADDR_W'(CTL_PORT));
  assign inWindow = (int'(idxQ) >= WIN_BASE) && (int'(idxQ) <= WIN_LAST);
  assign armWr    = ioWrEn && hitCtl && ioWrData[ARM_BIT] && protEnable;

  always_comb begin
    stb.blocked = lockQ && inWindow;
    stb.idxWr   = ioWrEn && hitIdx;
    stb.ramWr   = ioWrEn && hitData && !stb.blocked;
    stb.rdRam   = ioRdEn && hitData;
    stb.rdCtl   = ioRdEn && hitCtl;
  end

  // One-way lock: only reset clears it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lockQ <= 1'b0;
    else if (armWr) lockQ <= 1'b1;
  end

  // Two-flop synchronizer plus history flop for edge detect
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[1:0], pwrDetect};
  end

  assign vrtClr = syncQ[1] && !syncQ[2];

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> lockQ); // R6

  AST_ARM_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockQ) |-> $past(protEnable)); // R7

endmodule

// File: rtl/cmos_lock_datapath.sv
module cmos_lock_datapath
  import cmos_lock_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DEPTH    = 128,
  parameter int STAT_OFF = 'h0D,
  parameter int WIN_BASE = 'h38,
  parameter int WIN_SIZE = 8,
  parameter int ARM_BIT  = 3,
  localparam int IDX_W   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      stb,
  input  logic              lockIn,
  input  logic              vrtClr,
  input  logic [DATA_W-1:0] wrData,
  output logic [IDX_W-1:0]  idxQ,
  output logic [DATA_W-1:0] rdData
);

  localparam int WIN_LAST = WIN_BASE + WIN_SIZE - 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              vrtQ;
  logic              isStat;
  logic [DATA_W-1:0] ramByte, ctlByte;

  assign isStat = (idxQ == IDX_W'(STAT_OFF));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          idxQ <= '0;
    else if (stb.idxWr) idxQ <= wrData[IDX_W-1:0];
  end

  // Storage is battery backed: no reset
  always_ff @(posedge clk) begin
    if (stb.ramWr) mem[idxQ] <= wrData;
  end

  // Validity flag: a power edge wins over a same-cycle write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  vrtQ <= 1'b0;
    else if (vrtClr)            vrtQ <= 1'b0;
    else if (stb.ramWr && isStat) vrtQ <= wrData[DATA_W-1];
  end

  always_comb begin
    ramByte = mem[idxQ];
    if (isStat) ramByte[DATA_W-1] = vrtQ;
    ctlByte = '0;
    ctlByte[ARM_BIT] = lockIn;
    if (stb.rdRam)      rdData = stb.blocked ? '1 : ramByte;
    else if (stb.rdCtl) rdData = ctlByte;
    else                rdData = '0;
  end

  AST_NO_BLOCKED_WR: assert property (@(posedge clk) disable iff (!rstN)
    stb.ramWr |-> !(lockIn && int'(idxQ) >= WIN_BASE && int'(idxQ) <= WIN_LAST)); // R5

  AST_BLOCKED_RD_FF: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdRam && stb.blocked) |-> (rdData == '1)); // R4

  AST_VRT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    vrtClr |=> !vrtQ); // R9

endmodule

// File: rtl/cmos_lock_top.sv
module cmos_lock_top
  import cmos_lock_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioWrEn,
  input  logic              ioRdEn,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [DATA_W-1:0] ioWrData,
  output logic [DATA_W-1:0] ioRdData,
  input  logic              protEnable,
  input  logic              pwrDetect
);

  ctrlStrobes_t    stb;
  logic            lockQ, vrtClr;
  logic [IDX_W-1:0] idxQ;

  cmos_lock_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN), .ioWrEn(ioWrEn), .ioRdEn(ioRdEn),
    .ioAddr(ioAddr), .ioWrData(ioWrData), .protEnable(protEnable),
    .pwrDetect(pwrDetect), .idxQ(idxQ), .stb(stb), .lockQ(lockQ),
    .vrtClr(vrtClr)
  );

  cmos_lock_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .lockIn(lockQ), .vrtClr(vrtClr),
    .wrData(ioWrData), .idxQ(idxQ), .rdData(ioRdData)
  );

endmodule

// File: tb/cmos_lock_top_test.sv
module cmos_lock_top_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ioWrEn = 1'b0, ioRdEn = 1'b0;
  logic [15:0] ioAddr = '0;
  logic [7:0]  ioWrData = '0;
  logic [7:0]  ioRdData;
  logic        protEnable = 1'b1, pwrDetect = 1'b0;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  cmos_lock_top uut (
    .clk(clk), .rstN(rstN), .ioWrEn(ioWrEn), .ioRdEn(ioRdEn),
    .ioAddr(ioAddr), .ioWrData(ioWrData), .ioRdData(ioRdData),
    .protEnable(protEnable), .pwrDetect(pwrDetect)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic ioWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    ioWrEn = 1'b1; ioAddr = a; ioWrData = d;
    @(negedge clk);
    ioWrEn = 1'b0;
  endtask

  task automatic ioRead(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    ioRdEn = 1'b1; ioAddr = a;
    #1 d = ioRdData;
    ioRdEn = 1'b0;
  endtask

  task automatic ramWrite(input logic [7:0] off, input logic [7:0] d);
    ioWrite(16'h70, off);
    ioWrite(16'h71, d);
  endtask

  task automatic ramCheck(input string req, input logic [7:0] off, input logic [7:0] exp);
    logic [7:0] d;
    ioWrite(16'h70, off);
    ioRead(16'h71, d);
    check(req, d, exp);
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk); rstN = 1'b1;
  endtask

  task automatic tReset();
    logic [7:0] d;
    ioRead(16'h92, d);
    check("R1 ctl port after reset", d, 8'h00);
    ioWrite(16'h70, 8'h0D);
    ioRead(16'h71, d);
    check("R1 validity flag after reset", d & 8'h80, 8'h00);
  endtask

  task automatic tAccess();
    ramWrite(8'h10, 8'hA5);
    ramWrite(8'h7F, 8'h3C);
    ramWrite(8'h40, 8'h5A);
    ramCheck("R2 general byte", 8'h10, 8'hA5);
    ramCheck("R2 upper bank top", 8'h7F, 8'h3C);
    ramCheck("R2 index bit7 ignored", 8'hC0, 8'h5A);
  endtask

  task automatic tValidity();
    ramWrite(8'h0D, 8'h85);
    ramCheck("R9 flag set by write", 8'h0D, 8'h85);
    @(negedge clk); pwrDetect = 1'b1;
    repeat (3) @(negedge clk);
    ramCheck("R9 flag cleared by edge", 8'h0D, 8'h05);
    ramWrite(8'h0D, 8'h8A);
    repeat (4) @(negedge clk);
    ramCheck("R9 held-high detect no reclear", 8'h0D, 8'h8A);
    pwrDetect = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic tDisabledArm();
    logic [7:0] d;
    protEnable = 1'b0;
    ramWrite(8'h38, 8'h11);
    ramWrite(8'h3F, 8'h22);
    ioWrite(16'h92, 8'h08);
    ioRead(16'h92, d);
    check("R7 arm ignored when disabled", d, 8'h00);
    ramCheck("R7 window still readable", 8'h38, 8'h11);
  endtask

  task automatic tLock();
    logic [7:0] d;
    protEnable = 1'b1;
    ramWrite(8'h37, 8'h33);
    ioWrite(16'h92, 8'h08);
    ioRead(16'h92, d);
    check("R3 lock visible in bit 3", d, 8'h08);
    ramCheck("R4 window low edge blocked", 8'h38, 8'hFF);
    ramCheck("R4 window high edge blocked", 8'h3F, 8'hFF);
    ramCheck("R4 below window open", 8'h37, 8'h33);
    ramCheck("R4 above window open", 8'h40, 8'h5A);
    ramWrite(8'h38, 8'h99);  // R5: must be discarded
  endtask

  task automatic tSticky();
    logic [7:0] d;
    ioWrite(16'h92, 8'h00);
    ioRead(16'h92, d);
    check("R6 zero write keeps lock", d, 8'h08);
    protEnable = 1'b0;
    repeat (2) @(negedge clk);
    ioRead(16'h92, d);
    check("R6 enable drop keeps lock", d, 8'h08);
    ramCheck("R6 window still blocked", 8'h3F, 8'hFF);
  endtask

  task automatic tResetUnlock();
    logic [7:0] d;
    doReset();
    ioRead(16'h92, d);
    check("R8 reset clears lock", d, 8'h00);
    ramCheck("R5 blocked write discarded", 8'h38, 8'h11);
    ramCheck("R8 window readable after reset", 8'h3F, 8'h22);
    ramCheck("R8 RAM kept over reset", 8'h7F, 8'h3C);
    ramWrite(8'h3F, 8'h77);
    ramCheck("R8 window writable after reset", 8'h3F, 8'h77);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tAccess();
    tValidity();
    tDisabledArm();
    tLock();
    tSticky();
    tResetUnlock();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule